// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates a 32-bit effective address through a small set of block mappings. Each mapping is a pair of registers, an upper word and a lower word, and places one naturally aligned block, between 128 KiB and 256 MiB in size, directly onto physical memory. There are two independent banks of pairs. Instruction fetches look only at the instruction bank. Loads and stores look only at the data bank.

A request gives the address, the access kind and whether the processor runs in user or supervisor state. One cycle later the block reports one of two outcomes. On a hit it returns the physical address, the read, write and execute rights of the mapping, and a fault flag that says whether the requested access is denied. On a miss it reports that no mapping applies, so that a slower page-based translation can take over.

The pairs are searched from index 0 upward. The first pair that matches and is valid for the current privilege decides the result, even when that pair denies the access.

Top module: `bat_matcher`

## Requirements
- R1: Each request with `req_valid` high at a rising edge produces exactly one response, with `rsp_valid` high in the following cycle. `rsp_valid` is low in every cycle that does not follow such a request.
- R2: Register writes take effect for any request sampled after the write edge. When `wr_en` is high:
  - `wr_ifetch_bank` = 1 selects the instruction bank and 0 selects the data bank.
  - `wr_idx` selects the pair.
  - `wr_lower` = 1 selects the lower word and 0 selects the upper word.
  
  Reset clears every register to zero.
- R3: A pair matches when both of these hold, with the block mask being upper bits 12..2 aligned onto address bits 27..17:
  - Address bits 31..28 equal upper bits 31..28.
  - Address bits 27..17, with the masked positions cleared, equal upper bits 27..17.
  
  A stored upper bit set at a masked position therefore prevents any match.
- R4: A pair is valid for supervisor requests (`req_user` = 0) when upper bit 1 is set. It is valid for user requests (`req_user` = 1) when upper bit 0 is set.
- R5: `req_kind` encodes the access as follows: 2'b00 load, 2'b01 store, 2'b10 fetch, 2'b11 fetch. Fetches search only the instruction bank. Loads and stores search only the data bank.
- R6: Lower bits 1..0 set the rights on a hit:
  - 0 grants nothing.
  - 2 grants read, write and execute.
  - 1 or 3 grant read and execute only.
- R7: On a hit, `rsp_fault` is 1 when the needed right is absent. A load needs read, a store needs write and a fetch needs execute.
- R8: Among several matching valid pairs, the lowest index decides all outputs, including a fault when that pair denies the access.
- R9: On a hit, the physical address is assembled as follows:
  - Bits 31..28 are lower bits 31..28.
  - Bits 27..17 are lower bits 27..17 ORed with (address bits 27..17 AND the mask).
  - Bits 16..0 are address bits 16..0.
- R10: When no valid pair matches, the response has `rsp_miss` = 1 and `rsp_hit` = 0. The physical address, all rights and the fault flag are zero in that case.
- R11: During and right after reset, `rsp_valid`, `rsp_hit` and `rsp_miss` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ifetch_bank | input | 1 | Write target bank: 1 instruction, 0 data |
| wr_idx | input | IDX_W | Pair index to write |
| wr_lower | input | 1 | Write target word: 1 lower, 0 upper |
| wr_data | input | 32 | Register write value |
| req_valid | input | 1 | Translation request strobe |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 1x fetch |
| req_user | input | 1 | 1 for user state, 0 for supervisor |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A valid pair matched |
| rsp_miss | output | 1 | No valid pair matched |
| rsp_pa | output | 32 | Physical address |
| rsp_read | output | 1 | Read right of the deciding pair |
| rsp_write | output | 1 | Write right of the deciding pair |
| rsp_exec | output | 1 | Execute right of the deciding pair |
| rsp_fault | output | 1 | Requested access denied by the deciding pair |

## Verification
The bench builds the block with its default of four pairs per bank, which gives a two-bit pair index. With four pairs, every priority position can be exercised: a deciding pair can sit at index 0 with overlapping pairs behind it, or at the last index with nothing after it. The directed cases cover the smallest and largest block sizes, a partial mask, and a stored bit under the mask. They also cover user-only and supervisor-only entries and cross-bank isolation. A randomized phase then aims addresses into randomly configured blocks in both banks.

// File: rtl/bat_matcher.sv
module bat_matcher #(
  parameter int NUM_PAIRS = 4,
  localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_ifetch_bank,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_lower,
  input  logic [31:0]      wr_data,
  input  logic             req_valid,
  input  logic [31:0]      req_ea,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic [31:0]      rsp_pa,
  output logic             rsp_read,
  output logic             rsp_write,
  output logic             rsp_exec,
  output logic             rsp_fault
);

  // upper word kept as {31:28, 27:17, mask 12:2, valid 1:0}
  // lower word kept as {31:28, 27:17, pp 1:0}
  logic [27:0] upr [2][NUM_PAIRS];
  logic [16:0] lwr [2][NUM_PAIRS];

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data[16:13];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NUM_PAIRS; i++) begin
          upr[b][i] <= '0;
          lwr[b][i] <= '0;
        end
    end else if (wr_en) begin
      if (wr_lower)
        lwr[wr_ifetch_bank][wr_idx] <= {wr_data[31:17], wr_data[1:0]};
      else
        upr[wr_ifetch_bank][wr_idx] <= {wr_data[31:17], wr_data[12:0]};
    end
  end

  logic fetch, store;
  assign fetch = req_kind[1];
  assign store = (req_kind == 2'b01);

  logic        found;
  logic [31:0] pa_c;
  logic [1:0]  pp_c;

  always_comb begin
    found = 1'b0;
    pa_c  = '0;
    pp_c  = '0;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      logic [27:0] u;
      logic [16:0] l;
      logic [10:0] msk;
      u   = upr[fetch][i];
      l   = lwr[fetch][i];
      msk = u[12:2];
      if (!found && req_ea[31:28] == u[27:24] &&
          (req_ea[27:17] & ~msk) == u[23:13] &&
          (req_user ? u[0] : u[1])) begin
        found = 1'b1;
        pp_c  = l[1:0];
        pa_c  = {l[16:13], (req_ea[27:17] & msk) | l[12:2], req_ea[16:0]};
      end
    end
  end

  logic r_c, w_c, x_c, f_c;
  assign r_c = found && (pp_c != 2'b00);
  assign x_c = r_c;
  assign w_c = found && (pp_c == 2'b10);
  assign f_c = found && (fetch ? !x_c : (store ? !w_c : !r_c));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_pa    <= '0;
      rsp_read  <= 1'b0;
      rsp_write <= 1'b0;
      rsp_exec  <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && found;
      rsp_miss  <= req_valid && !found;
      rsp_pa    <= (req_valid && found) ? pa_c : '0;
      rsp_read  <= req_valid && r_c;
      rsp_write <= req_valid && w_c;
      rsp_exec  <= req_valid && x_c;
      rsp_fault <= req_valid && f_c;
    end
  end

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_hit_xor_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_miss));
  p_miss_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pa == 32'd0 && !rsp_read && !rsp_write && !rsp_exec && !rsp_fault));
  p_fault_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit);
  p_write_implies_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_write |-> (rsp_read && rsp_exec));
  p_offset_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rst_n) |=> (!rsp_hit || rsp_pa[16:0] == $past(req_ea[16:0])));

endmodule

// File: tb/bat_matcher_tb_top.sv
`timescale 1ns/1ps
module bat_matcher_tb_top;
  localparam int NP = 4;
  localparam int IW = 2;

  typedef struct packed {
    logic        hit;
    logic        miss;
    logic [31:0] pa;
    logic        r;
    logic        w;
    logic        x;
    logic        f;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_ifetch_bank = 1'b0, wr_lower = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic req_valid = 1'b0, req_user = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0] req_kind = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_read, rsp_write, rsp_exec, rsp_fault;
  logic [31:0] rsp_pa;

  always #4 clk = ~clk;

  bat_matcher #(.NUM_PAIRS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ifetch_bank(wr_ifetch_bank),
    .wr_idx(wr_idx), .wr_lower(wr_lower), .wr_data(wr_data),
    .req_valid(req_valid), .req_ea(req_ea), .req_kind(req_kind), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa),
    .rsp_read(rsp_read), .rsp_write(rsp_write), .rsp_exec(rsp_exec), .rsp_fault(rsp_fault)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  exp_t  exp_q [$];
  string tag_q [$];
  logic [31:0] sh_u [0:1][0:NP-1];
  logic [31:0] sh_l [0:1][0:NP-1];

  function automatic exp_t model(logic [31:0] ea, logic [1:0] kind, logic user);
    exp_t e;
    logic bank;
    bit seen;
    e = '0;
    seen = 1'b0;
    bank = kind[1];
    for (int i = 0; i < NP; i++) begin
      logic [31:0] u, l;
      logic [10:0] m;
      u = sh_u[bank][i];
      l = sh_l[bank][i];
      m = u[12:2];
      if (!seen && ea[31:28] == u[31:28] && ((ea[27:17] & ~m) == u[27:17]) &&
          (user ? u[0] : u[1])) begin
        seen = 1'b1;
        e.hit = 1'b1;
        e.pa = {l[31:28], l[27:17] | (ea[27:17] & m), ea[16:0]};
        e.r = (l[1:0] != 2'b00);
        e.x = e.r;
        e.w = (l[1:0] == 2'b10);
        if (kind[1]) e.f = !e.x;
        else if (kind[0]) e.f = !e.w;
        else e.f = !e.r;
      end
    end
    e.miss = !seen;
    return e;
  endfunction

  task automatic wr(input logic bank, input int idx, input logic lower, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    wr_en = 1'b1; wr_ifetch_bank = bank; wr_idx = idx[IW-1:0]; wr_lower = lower; wr_data = d;
    if (lower) sh_l[bank][idx] = d; else sh_u[bank][idx] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pair(input logic bank, input int idx, input logic [31:0] u, input logic [31:0] l);
    wr(bank, idx, 1'b0, u);
    wr(bank, idx, 1'b1, l);
  endtask

  task automatic req(input logic [31:0] ea, input logic [1:0] kind, input logic user, input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    req_valid = 1'b1; req_ea = ea; req_kind = kind; req_user = user;
    exp_q.push_back(model(ea, kind, user));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) begin
          vectors++; fails++;
          $display("FAIL R1: response with no request, actual valid=%0b expected valid=0", rsp_valid);
        end else begin
          exp_t e, a;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          a = '{rsp_hit, rsp_miss, rsp_pa, rsp_read, rsp_write, rsp_exec, rsp_fault};
          vectors++;
          if (a !== e) begin
            fails++;
            $display("FAIL %s: actual hit=%0b miss=%0b pa=%h rwx=%0b%0b%0b f=%0b expected hit=%0b miss=%0b pa=%h rwx=%0b%0b%0b f=%0b",
              t, a.hit, a.miss, a.pa, a.r, a.w, a.x, a.f, e.hit, e.miss, e.pa, e.r, e.w, e.x, e.f);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : driver
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < NP; i++) begin
        sh_u[b][i] = '0; sh_l[b][i] = '0;
      end
    repeat (3) @(posedge clk);
    #2;
    vectors++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0) begin
      fails++;
      $display("FAIL R11: actual v/h/m=%0b%0b%0b expected 000", rsp_valid, rsp_hit, rsp_miss);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    vectors++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11: after reset actual valid=%0b expected 0", rsp_valid);
    end

    // cleared registers: everything misses
    req(32'h0000_0000, 2'b00, 1'b0, "R2 reset-clear miss");
    req(32'h1234_5678, 2'b10, 1'b1, "R10 miss");
    idle();

    // data pair 0: 128 KiB at 0x1002_0000, supervisor only, rwx
    pair(1'b0, 0, 32'h1002_0002, 32'h8004_0002);
    req(32'h1002_0ABC, 2'b00, 1'b0, "R9 small block load");
    req(32'h1003_FFFF, 2'b01, 1'b0, "R6 store allowed");
    req(32'h1004_0000, 2'b00, 1'b0, "R3 outside block");
    req(32'h1002_0ABC, 2'b10, 1'b0, "R5 fetch uses other bank");
    req(32'h1002_0ABC, 2'b00, 1'b1, "R4 user not valid");
    idle();

    // data pair 1: 256 MiB at 0x2000_0000, both states, read/exec only
    pair(1'b0, 1, 32'h2000_0000 | (32'h7FF << 2) | 32'h3, 32'h4000_0001);
    req(32'h2ABC_D123, 2'b00, 1'b1, "R9 large block load");
    req(32'h2ABC_D123, 2'b01, 1'b0, "R7 store fault");
    req(32'h3ABC_D123, 2'b00, 1'b0, "R3 top nibble exact");
    idle();

    // data pair 2 overlaps pair 0 with different target; pair 0 wins
    pair(1'b0, 2, 32'h1002_0003, 32'h9000_0002);
    req(32'h1002_1000, 2'b00, 1'b0, "R8 lowest index wins");
    req(32'h1002_1000, 2'b00, 1'b1, "R4 user falls to pair 2");
    idle();

    // instruction bank: pair 0 denies, pair 1 would allow; pair 0 decides
    pair(1'b1, 0, 32'h3000_0000 | (32'h3 << 2) | 32'h3, 32'h5000_0000);
    pair(1'b1, 1, 32'h3000_0000 | (32'h3 << 2) | 32'h3, 32'h6000_0002);
    req(32'h3004_0040, 2'b10, 1'b0, "R8 first match faults");
    req(32'h3004_0040, 2'b11, 1'b1, "R5 kind 11 is fetch");
    req(32'h3004_0040, 2'b00, 1'b0, "R5 load uses data bank");
    idle();

    // partial mask (512 KiB) at instruction pair 2, exec allowed
    pair(1'b1, 2, 32'h7008_0000 | (32'h3 << 2) | 32'h1, 32'hA010_0003);
    req(32'h700E_1234, 2'b10, 1'b1, "R9 partial mask");
    req(32'h7010_0000, 2'b10, 1'b1, "R3 beyond partial block");
    req(32'h700E_1234, 2'b10, 1'b0, "R4 supervisor not valid");
    idle();

    // stored bit under the mask: never matches (instr pair 3)
    pair(1'b1, 3, 32'hB002_0000 | (32'h1 << 2) | 32'h3, 32'hC000_0002);
    req(32'hB002_0000, 2'b10, 1'b0, "R3 stored masked bit");
    req(32'hB000_0000, 2'b10, 1'b0, "R3 stored masked bit");
    idle();

    // no-access pair in data bank: load faults
    pair(1'b0, 3, 32'hE000_0003, 32'hF000_0000);
    req(32'hE001_0000, 2'b00, 1'b0, "R6 pp zero load fault");
    idle();

    // randomized
    for (int n = 0; n < 40; n++) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NP; i++) begin
          logic [31:0] u;
          u = $urandom;
          u[31:28] = {3'b000, u[28]};
          u[27:17] = u[27:17] & ~u[12:2];
          pair(b[0], i, u, $urandom);
        end
      for (int k = 0; k < 12; k++) begin
        logic [31:0] ea, u;
        logic [1:0] kd;
        kd = 2'($urandom_range(0, 3));
        u = sh_u[kd[1]][$urandom_range(0, NP - 1)];
        ea = $urandom;
        if ($urandom_range(0, 3) != 0) begin
          ea[31:28] = u[31:28];
          ea[27:17] = u[27:17] | (ea[27:17] & u[12:2]);
        end
        req(ea, kd, 1'($urandom_range(0, 1)), "R8 random");
      end
      idle();
    end

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1: actual %0d responses missing expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule